// File: doc/BRIEF.md
# Battery Supply Selection Controller

This block decides which of two external battery supplies, a high-voltage one or a low-voltage one, feeds a telephone line interface. It drives a single select output that turns an external pass transistor on or off. It also reports the current choice through a status bit.

In automatic mode the choice follows the line state and the hook detectors. An off-hook indication from either the ring-trip detector or the loop-closure detector requests low battery. On-hook and the ringing state request high battery. In manual mode a single control bit sets the choice directly.

An optional debounce, counted on a 1 kHz tick, delays only the move from high to low battery. This keeps pulse dialing and brief hook flashes from toggling the supply. The move back to high battery is never delayed.

Top module: `bat_sel_ctrl`

## Requirements
- R1: After an asynchronous reset, `bat_low_o` and `bat_stat_o` are 0 (high battery) and the debounce count is cleared.
- R2: While `auto_i` is 0, `bat_low_o` equals the value `man_low_i` had at the previous clock edge. Any debounce in progress is dropped.
- R3: In automatic mode, low battery is requested when `ring_trip_i` or `loop_close_i` is 1 and `line_state_i` is not 2'b10 (ringing). With `dbnc_en_i` at 0, `bat_low_o` goes to 1 on the next clock.
- R4: In automatic mode, when no low request is present (no detect flag, or `line_state_i` is 2'b10), `bat_low_o` is 0 after the next clock, whether or not debounce is enabled.
- R5: With `dbnc_en_i` at 1, the change from high to low happens on the clock edge that carries the `DEBOUNCE_MS`-th `tick_i` pulse seen while the low request is continuously present.
- R6: With `dbnc_en_i` at 1, if the low request goes away before `DEBOUNCE_MS` ticks, the output stays at high battery. The tick count restarts from zero at the next request.
- R7: A change of `auto_i` from 1 to 0 during a debounce applies `man_low_i` on the next clock. A later return to automatic mode starts a fresh debounce count.
- R8: `bat_stat_o` equals `bat_low_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at 1 kHz |
| line_state_i | input | 2 | Line operating state; 2'b10 is ringing |
| ring_trip_i | input | 1 | Ring-trip detected |
| loop_close_i | input | 1 | Loop closure detected |
| auto_i | input | 1 | 1 selects automatic mode |
| man_low_i | input | 1 | Manual select, 1 = low battery |
| dbnc_en_i | input | 1 | Enables the high-to-low debounce |
| bat_low_o | output | 1 | Transistor select, 1 = low battery |
| bat_stat_o | output | 1 | Status copy of the current choice |

## Verification
The bench builds the block with the default `DEBOUNCE_MS` of 60 and issues a tick every fourth clock. A full debounce window therefore spans 240 cycles, and both an aborted window and a completed window fit in a short run. This lets the bench count ticks against the exact switching edge. It also covers a mode change in the middle of a window and a restart of the count after the request drops.

// File: rtl/bat_pkg.sv
package bat_pkg;
  typedef enum logic [1:0] {
    LS_IDLE   = 2'b00,
    LS_ACTIVE = 2'b01,
    LS_RING   = 2'b10,
    LS_REV    = 2'b11
  } line_state_e;
endpackage

// File: rtl/bat_req_decode.sv
module bat_req_decode
  import bat_pkg::*;
(
  input  logic [1:0] line_state_i,
  input  logic       ring_trip_i,
  input  logic       loop_close_i,
  output logic       want_low_o
);
  line_state_e ls;
  assign ls = line_state_e'(line_state_i);
  // ringing always needs the high supply
  assign want_low_o = (ring_trip_i | loop_close_i) && (ls != LS_RING);
endmodule

// File: rtl/bat_debounce.sv
module bat_debounce #(
  parameter int unsigned DEBOUNCE_MS = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = (DEBOUNCE_MS > 1) ? $clog2(DEBOUNCE_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_MS - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = arm_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!arm_i || done_o)   cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bat_sel_ctrl.sv
module bat_sel_ctrl #(
  parameter int unsigned DEBOUNCE_MS = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] line_state_i,
  input  logic       ring_trip_i,
  input  logic       loop_close_i,
  input  logic       auto_i,
  input  logic       man_low_i,
  input  logic       dbnc_en_i,
  output logic       bat_low_o,
  output logic       bat_stat_o
);
  logic want_low, arm, done, low_q, low_d;

  bat_req_decode i_req (
    .line_state_i (line_state_i),
    .ring_trip_i  (ring_trip_i),
    .loop_close_i (loop_close_i),
    .want_low_o   (want_low)
  );

  assign arm = auto_i && dbnc_en_i && want_low && !low_q;

  bat_debounce #(.DEBOUNCE_MS(DEBOUNCE_MS)) i_dbnc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .tick_i (tick_i),
    .done_o (done)
  );

  always_comb begin
    if (!auto_i)         low_d = man_low_i;
    else if (!want_low)  low_d = 1'b0;
    else if (!dbnc_en_i) low_d = 1'b1;
    else                 low_d = low_q | done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= 1'b0;
    else         low_q <= low_d;
  end

  assign bat_low_o  = low_q;
  assign bat_stat_o = low_q;
endmodule

// File: rtl/bat_sel_ctrl_chk.sv
module bat_sel_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [1:0] line_state_i,
  input logic       ring_trip_i,
  input logic       loop_close_i,
  input logic       auto_i,
  input logic       man_low_i,
  input logic       dbnc_en_i,
  input logic       bat_low_o,
  input logic       bat_stat_o
);
  logic req;
  assign req = (ring_trip_i | loop_close_i) && (line_state_i != 2'b10);

  a_r2_manual_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> (bat_low_o == $past(man_low_i)));

  a_r3_direct_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && !dbnc_en_i && req) |=> bat_low_o);

  a_r4_high_at_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && !req) |=> !bat_low_o);

  a_r5_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && dbnc_en_i && !tick_i && !bat_low_o) |=> !bat_low_o);

  a_r8_status_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bat_low_o) |-> $rose(bat_stat_o));
endmodule

bind bat_sel_ctrl bat_sel_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .line_state_i (line_state_i),
  .ring_trip_i  (ring_trip_i),
  .loop_close_i (loop_close_i),
  .auto_i       (auto_i),
  .man_low_i    (man_low_i),
  .dbnc_en_i    (dbnc_en_i),
  .bat_low_o    (bat_low_o),
  .bat_stat_o   (bat_stat_o)
);

// File: tb/test_bat_sel_ctrl.sv
module test_bat_sel_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEBOUNCE_MS = 60;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0;
  logic [1:0] line_state = 2'b00;
  logic ring_trip = 1'b0, loop_close = 1'b0;
  logic auto_m = 1'b1, man_low = 1'b0, dbnc_en = 1'b0;
  logic bat_low, bat_stat;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  int m_low = 0, m_cnt = 0;
  int tdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bat_sel_ctrl #(.DEBOUNCE_MS(DEBOUNCE_MS)) i_bat_sel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .line_state_i(line_state),
    .ring_trip_i(ring_trip), .loop_close_i(loop_close), .auto_i(auto_m),
    .man_low_i(man_low), .dbnc_en_i(dbnc_en), .bat_low_o(bat_low),
    .bat_stat_o(bat_stat)
  );

  // tick generator, changes shortly after the rising edge
  always @(posedge clk) begin
    #2;
    tdiv = (tdiv + 1) % TICK_DIV;
    tick = (tdiv == 0);
  end

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_low = 0; m_cnt = 0;
    end else begin
      bit req;
      req = (ring_trip || loop_close) && (line_state != 2'b10);
      if (!auto_m) begin
        m_low = man_low; m_cnt = 0;
      end else if (!req) begin
        m_low = 0; m_cnt = 0;
      end else if (!dbnc_en) begin
        m_low = 1; m_cnt = 0;
      end else if (m_low == 1) begin
        m_cnt = 0;
      end else if (tick) begin
        m_cnt++;
        if (m_cnt == DEBOUNCE_MS) begin m_low = 1; m_cnt = 0; end
      end
    end
  end

  always @(negedge clk) begin
    compared++;
    if (bat_low !== m_low[0]) begin
      mismatched++;
      $display("FAIL %s bat_low_o=%b expected=%0d t=%0t", cur_req, bat_low, m_low, $time);
    end
    compared++;
    if (bat_stat !== bat_low) begin
      mismatched++;
      $display("FAIL R8 bat_stat_o=%b expected=%b t=%0t", bat_stat, bat_low, $time);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cur_req = "R1";
    step(3);
    rst_n = 1'b1;
    step(3);
    // R3: direct switching without debounce
    cur_req = "R3";
    loop_close = 1'b1; step(3);
    loop_close = 1'b0; cur_req = "R4"; step(2);
    cur_req = "R3"; ring_trip = 1'b1; line_state = 2'b01; step(3);
    // R4: ringing overrides the detectors
    cur_req = "R4"; line_state = 2'b10; step(3);
    ring_trip = 1'b0; line_state = 2'b00; step(2);
    // R2: manual override
    cur_req = "R2"; auto_m = 1'b0; man_low = 1'b1; step(3);
    man_low = 1'b0; step(2); man_low = 1'b1; step(1);
    loop_close = 1'b1; man_low = 1'b0; step(3);
    loop_close = 1'b0; auto_m = 1'b1; step(2);
    // R6: short off-hook under debounce stays high
    cur_req = "R6"; dbnc_en = 1'b1;
    loop_close = 1'b1; step(30 * TICK_DIV);
    loop_close = 1'b0; step(5);
    loop_close = 1'b1; step(40 * TICK_DIV);
    // R5: held long enough, switches on the final tick
    cur_req = "R5"; step(25 * TICK_DIV);
    // R4: return to high is immediate even with debounce on
    cur_req = "R4"; loop_close = 1'b0; step(3);
    // R7: mode change mid-window abandons the count
    cur_req = "R7"; ring_trip = 1'b1; step(50 * TICK_DIV);
    auto_m = 1'b0; man_low = 1'b1; step(3);
    man_low = 1'b0; auto_m = 1'b1; step(20 * TICK_DIV);
    step(45 * TICK_DIV);
    ring_trip = 1'b0; step(3);
    // R1: reset in the middle of low battery
    cur_req = "R1"; dbnc_en = 1'b0; loop_close = 1'b1; step(2);
    rst_n = 1'b0; step(2);
    loop_close = 1'b0; rst_n = 1'b1; step(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule